// File: doc/BRIEF.md
# Paged Module-Information Memory Target

This block is a two-wire serial bus target (I2C/SMBus signalling) that presents a 512-byte module-information store to a host controller. The store is split into two 256-byte pages, and only one of them is visible to data transfers at a time. Bus writes to two dedicated command addresses pick the page. Each page is divided into two 128-byte blocks, which gives four blocks in total. Any block can be made read-only, and one command removes protection from all blocks together. Protection can only change while a strap input is high. That strap stands in for the raised voltage that a real part would see on its lowest slot pin.

The host addresses the memory at a 7-bit address built from a fixed prefix and three slot pins. A write transfer sends one word-address byte first, then data bytes. A read transfer returns bytes from the current word pointer. The pointer steps after every data byte and wraps inside the selected page. The target samples SCL and SDA with the system clock and drives SDA low through an output-enable only. It never stretches the clock. The contents are held in registers.

Top module: `paged_spd_target`

## Requirements
- R1: After reset the visible page is page 0, no block is protected, and `sda_oe` is low.
- R2: An address byte whose upper seven bits equal binary 1010 followed by `slot_sel[2:0]` is acknowledged (SDA held low on the 9th clock), whether bit 0 (R/W, 1 = read) is set or clear. An address byte matching neither the memory address nor an enabled command is not acknowledged, and SDA is left released.
- R3: In a write transfer, the first byte after the address loads the word pointer. Every following byte is acknowledged and stored at `{page, pointer}`, and the pointer then advances by one.
- R4: In a read transfer, the target sends the byte at `{page, pointer}` MSB first and the pointer advances by one. A controller ACK requests the next byte. After a controller NACK, SDA stays released until the next START or STOP.
- R5: The word pointer wraps from 0xFF to 0x00 and stays inside the selected page. The pointer keeps its value from one transfer to the next.
- R6: A write-direction address byte at 7-bit address 0x36 selects page 0 and one at 0x37 selects page 1. Both are acknowledged whatever the strap level. The page remains selected until the next such command.
- R7: Byte `w` of page `p` lies in block `2*p + w[7]`. A data byte written into a protected block is acknowledged, but the stored byte does not change.
- R8: While `hv_strap` is high, a write-direction address at 0x30, 0x31, 0x32 or 0x33 protects block 0, 1, 2 or 3, and 0x34 unprotects all four blocks. Each of these is acknowledged. While `hv_strap` is low, the same addresses are not acknowledged and protection is unchanged.
- R9: Data bytes that follow an acknowledged command address are not acknowledged. Read-direction bytes at the command addresses (0x30 to 0x37) are not acknowledged.
- R10: A repeated START returns the target to the address phase, which allows a pointer-setting write followed by a read. A STOP returns the target to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| slot_sel | input | 3 | Slot pins forming the low address bits |
| hv_strap | input | 1 | High while protection changes are allowed |

## Verification
If the page register is wrong, the next read returns bytes from the other page. This shows within one transfer after the bad page command, so the bench reads back across both pages after every selection. If the protection mask is wrong, a stored byte either changes when it should not or fails to change. This appears only on the read that follows the write, so each protection case writes and then reads the same word in the block concerned. If the pointer or the byte engine is wrong, the error shows up at once as a missing or extra acknowledge bit on the 9th clock, or as SDA still held after a NACK. The bench samples both in the middle of the clock-high phase.

// File: rtl/spd_pkg.sv
package spd_pkg;

  localparam logic [3:0] MEM_PREFIX = 4'b1010;
  localparam logic [3:0] CMD_PREFIX = 4'b0110;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_WORD,
    ST_ACK_WORD,
    ST_WDATA,
    ST_ACK_WDATA,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } link_state_e;

  typedef enum logic [2:0] {
    DEC_NONE,
    DEC_MEM,
    DEC_PAGE,
    DEC_WP_SET,
    DEC_WP_CLR
  } dec_kind_e;

  typedef struct packed {
    dec_kind_e  kind;
    logic [1:0] arg;
    logic       rd;
  } dec_t;

  // Classify a received address byte (7-bit address plus R/W in bit 0).
  function automatic dec_t decode_addr(input logic [7:0] b,
                                       input logic [2:0] sa,
                                       input logic       hv);
    dec_t d;
    d.kind = DEC_NONE;
    d.arg  = 2'b00;
    d.rd   = b[0];
    if (b[7:1] == {MEM_PREFIX, sa}) begin
      d.kind = DEC_MEM;
    end else if (b[7:4] == CMD_PREFIX && !b[0]) begin
      case (b[3:1])
        3'd6, 3'd7: begin
          d.kind = DEC_PAGE;
          d.arg  = {1'b0, b[1]};
        end
        3'd0, 3'd1, 3'd2, 3'd3: begin
          if (hv) begin
            d.kind = DEC_WP_SET;
            d.arg  = b[2:1];
          end
        end
        3'd4: begin
          if (hv) d.kind = DEC_WP_CLR;
        end
        default: d.kind = DEC_NONE;
      endcase
    end
    return d;
  endfunction

  // Block number from the page and the top bit of the word pointer.
  function automatic logic [1:0] block_of(input logic page, input logic word_msb);
    return {page, word_msb};
  endfunction

endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_p;
  logic              sda_p;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_in;
          sda_q <= sda_in;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[STAGES-2:0], scl_in};
          sda_q <= {sda_q[STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/spd_link_fsm.sv
module spd_link_fsm
  import spd_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [2:0]    slot_sel,
  input  logic          hv_strap,
  input  logic [7:0]    rd_byte,
  output logic          sda_oe,
  output logic          ptr_load,
  output logic [AW-1:0] ptr_val,
  output logic          ptr_inc,
  output logic          wr_en,
  output logic [7:0]    wr_data,
  output logic          page_evt,
  output logic          page_val,
  output logic          wp_set_evt,
  output logic [1:0]    wp_idx,
  output logic          wp_clr_evt,
  output link_state_e   state
);

  logic [3:0] cnt;
  logic [7:0] shreg;
  logic [7:0] txreg;
  logic       rd_mode;
  logic       cmd_mode;
  logic       quiet;
  logic       byte_end;
  logic       tx_load;
  dec_t       dec;

  assign quiet    = !start_det && !stop_det;
  assign byte_end = quiet && scl_fall && (cnt == 4'd8);
  assign dec      = decode_addr(shreg, slot_sel, hv_strap);

  // Named events consumed by the storage and the checker.
  assign page_evt   = (state == ST_ADDR) && byte_end && (dec.kind == DEC_PAGE);
  assign page_val   = dec.arg[0];
  assign wp_set_evt = (state == ST_ADDR) && byte_end && (dec.kind == DEC_WP_SET);
  assign wp_idx     = dec.arg;
  assign wp_clr_evt = (state == ST_ADDR) && byte_end && (dec.kind == DEC_WP_CLR);
  assign ptr_load   = (state == ST_WORD) && byte_end;
  assign ptr_val    = shreg[AW-1:0];
  assign wr_en      = (state == ST_WDATA) && byte_end;
  assign wr_data    = shreg;
  assign tx_load    = quiet && scl_fall &&
                      (((state == ST_ACK_ADDR) && rd_mode && !cmd_mode) ||
                       ((state == ST_RACK) && !shreg[0]));
  assign ptr_inc    = wr_en || tx_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= 4'd0;
      shreg    <= 8'd0;
      txreg    <= 8'd0;
      sda_oe   <= 1'b0;
      rd_mode  <= 1'b0;
      cmd_mode <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      cnt    <= 4'd0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      cnt    <= 4'd0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WORD, ST_WDATA: begin
          if (scl_rise && cnt != 4'd8) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end
          if (byte_end) begin
            cnt <= 4'd0;
            if (state == ST_ADDR) begin
              if (dec.kind != DEC_NONE) begin
                sda_oe   <= 1'b1;
                state    <= ST_ACK_ADDR;
                rd_mode  <= (dec.kind == DEC_MEM) && dec.rd;
                cmd_mode <= (dec.kind != DEC_MEM);
              end else begin
                state <= ST_WAIT;
              end
            end else if (state == ST_WORD) begin
              sda_oe <= 1'b1;
              state  <= ST_ACK_WORD;
            end else begin
              sda_oe <= 1'b1;
              state  <= ST_ACK_WDATA;
            end
          end
        end
        ST_ACK_ADDR: begin
          if (scl_fall) begin
            cnt <= 4'd0;
            if (cmd_mode) begin
              sda_oe <= 1'b0;
              state  <= ST_WAIT;
            end else if (rd_mode) begin
              txreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
              state  <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WORD;
            end
          end
        end
        ST_ACK_WORD, ST_ACK_WDATA: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= 4'd0;
            state  <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise && cnt != 4'd8) cnt <= cnt + 4'd1;
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              cnt    <= 4'd0;
              state  <= ST_RACK;
            end else begin
              txreg  <= {txreg[6:0], 1'b0};
              sda_oe <= ~txreg[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) shreg[0] <= sda_s;
          if (scl_fall) begin
            if (!shreg[0]) begin
              txreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
              cnt    <= 4'd0;
              state  <= ST_RDATA;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: begin
          sda_oe <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/spd_store.sv
module spd_store
  import spd_pkg::*;
#(
  parameter int PAGE_BYTES = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ptr_load,
  input  logic [$clog2(PAGE_BYTES)-1:0] ptr_val,
  input  logic                          ptr_inc,
  input  logic                          wr_en,
  input  logic [7:0]                    wr_data,
  input  logic                          page_evt,
  input  logic                          page_val,
  input  logic                          wp_set_evt,
  input  logic [1:0]                    wp_idx,
  input  logic                          wp_clr_evt,
  output logic [7:0]                    rd_byte,
  output logic                          cur_page,
  output logic [3:0]                    wp_mask,
  output logic [$clog2(PAGE_BYTES)-1:0] word_ptr,
  output logic                          wr_commit
);

  localparam int AW     = $clog2(PAGE_BYTES);
  localparam int PAGES  = 2;
  localparam int DEPTH  = PAGE_BYTES * PAGES;
  localparam int NBLK   = 4;

  logic [7:0]      mem [DEPTH];
  logic [AW:0]     flat_addr;
  logic [1:0]      cur_blk;

  assign flat_addr = {cur_page, word_ptr};
  assign cur_blk   = block_of(cur_page, word_ptr[AW-1]);
  assign rd_byte   = mem[flat_addr];
  assign wr_commit = wr_en && !wp_mask[cur_blk];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_ptr <= '0;
    end else if (ptr_load) begin
      word_ptr <= ptr_val;
    end else if (ptr_inc) begin
      word_ptr <= word_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_page <= 1'b0;
    end else if (page_evt) begin
      cur_page <= page_val;
    end
  end

  generate
    for (genvar g = 0; g < NBLK; g++) begin : g_wp
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wp_mask[g] <= 1'b0;
        end else if (wp_clr_evt) begin
          wp_mask[g] <= 1'b0;
        end else if (wp_set_evt && wp_idx == g[1:0]) begin
          wp_mask[g] <= 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_commit) mem[flat_addr] <= wr_data;
  end

endmodule

// File: rtl/paged_spd_target.sv
module paged_spd_target
  import spd_pkg::*;
#(
  parameter int PAGE_BYTES  = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [2:0] slot_sel,
  input  logic       hv_strap
);

  localparam int AW = $clog2(PAGE_BYTES);

  logic          scl_s;
  logic          sda_s;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_det;
  logic          stop_det;
  logic [7:0]    rd_byte;
  logic          ptr_load;
  logic [AW-1:0] ptr_val;
  logic          ptr_inc;
  logic          wr_en;
  logic [7:0]    wr_data;
  logic          page_evt;
  logic          page_val;
  logic          wp_set_evt;
  logic [1:0]    wp_idx;
  logic          wp_clr_evt;
  logic          cur_page;
  logic [3:0]    wp_mask;
  logic [AW-1:0] word_ptr;
  logic          wr_commit;
  link_state_e   link_state;

  spd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  spd_link_fsm #(.AW(AW)) u_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .slot_sel   (slot_sel),
    .hv_strap   (hv_strap),
    .rd_byte    (rd_byte),
    .sda_oe     (sda_oe),
    .ptr_load   (ptr_load),
    .ptr_val    (ptr_val),
    .ptr_inc    (ptr_inc),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .page_evt   (page_evt),
    .page_val   (page_val),
    .wp_set_evt (wp_set_evt),
    .wp_idx     (wp_idx),
    .wp_clr_evt (wp_clr_evt),
    .state      (link_state)
  );

  spd_store #(.PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr_load   (ptr_load),
    .ptr_val    (ptr_val),
    .ptr_inc    (ptr_inc),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .page_evt   (page_evt),
    .page_val   (page_val),
    .wp_set_evt (wp_set_evt),
    .wp_idx     (wp_idx),
    .wp_clr_evt (wp_clr_evt),
    .rd_byte    (rd_byte),
    .cur_page   (cur_page),
    .wp_mask    (wp_mask),
    .word_ptr   (word_ptr),
    .wr_commit  (wr_commit)
  );

endmodule

// File: rtl/spd_checker.sv
module spd_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          scl_s,
  input logic          page,
  input logic [3:0]    wp,
  input logic [AW-1:0] ptr,
  input logic          wr_en,
  input logic          page_evt,
  input logic          wp_clr_evt,
  input logic          hv_strap
);

  // R8
  wp_needs_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp != $past(wp)) |-> $past(hv_strap));

  // R8
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_clr_evt |=> (wp == 4'b0000));

  // R6
  page_by_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page != $past(page)) |-> $past(page_evt));

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == $past(ptr) + 1'b1));

  // R2
  drive_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

endmodule

bind paged_spd_target spd_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sda_oe     (sda_oe),
  .scl_s      (scl_s),
  .page       (cur_page),
  .wp         (wp_mask),
  .ptr        (word_ptr),
  .wr_en      (wr_en),
  .page_evt   (page_evt),
  .wp_clr_evt (wp_clr_evt),
  .hv_strap   (hv_strap)
);

// File: tb/paged_spd_target_bench.sv
module paged_spd_target_bench;

  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_low = 1'b0;
  logic [2:0] sa = 3'd0;
  logic       hv = 1'b0;
  logic       sda_oe;
  logic       sda_line;
  logic       done = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [7:0] model [512];
  int         mpage = 0;
  bit [3:0]   mwp = 4'b0000;
  int         mptr = 0;

  always #5 clk = ~clk;

  assign sda_line = !(m_low || sda_oe);

  paged_spd_target u_paged_spd_target (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl),
    .sda_in   (sda_line),
    .sda_oe   (sda_oe),
    .slot_sel (sa),
    .hv_strap (hv)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Model: block of a word on a page, and the effect of one data write.
  function automatic int blk_index(input int page, input int word);
    return page * 2 + ((word >> 7) & 1);
  endfunction

  function automatic int flat(input int page, input int word);
    return page * 256 + word;
  endfunction

  task automatic model_write(input logic [7:0] d);
    if (!mwp[blk_index(mpage, mptr)]) model[flat(mpage, mptr)] = d;
    mptr = (mptr + 1) % 256;
  endtask

  // Bus primitives
  task automatic b_start();
    m_low = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    m_low = 1'b1; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic b_stop();
    m_low = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    m_low = 1'b0; tick(Q);
  endtask

  task automatic b_send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = !b[i]; tick(Q);
      scl = 1'b1;    tick(2 * Q);
      scl = 1'b0;    tick(Q);
    end
    m_low = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    ack = !sda_line;
    tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic b_recv(input bit give_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      scl = 1'b0; tick(Q);
    end
    m_low = give_ack; tick(Q);
    scl = 1'b1;       tick(2 * Q);
    scl = 1'b0;       tick(Q);
    m_low = 1'b0;
  endtask

  function automatic logic [7:0] mem_addr(input bit rd);
    return {4'b1010, sa, rd};
  endfunction

  // Write n bytes starting at word; every byte must be acknowledged.
  task automatic tx_write(input int word, input logic [7:0] d [4], input int n, input string req);
    bit ack;
    b_start();
    b_send(mem_addr(1'b0), ack);
    check_eq("R2", "write address ack", ack, 1);
    b_send(word[7:0], ack);
    check_eq("R3", "word address ack", ack, 1);
    mptr = word;
    for (int i = 0; i < n; i++) begin
      b_send(d[i], ack);
      check_eq(req, "data byte ack", ack, 1);
      model_write(d[i]);
    end
    b_stop();
  endtask

  // Set the pointer, repeated START, read n bytes, NACK the last one.
  task automatic tx_read(input int word, input int n, input string req);
    bit ack;
    logic [7:0] got;
    b_start();
    b_send(mem_addr(1'b0), ack);
    check_eq("R2", "address ack before read", ack, 1);
    b_send(word[7:0], ack);
    check_eq("R3", "word ack before read", ack, 1);
    mptr = word;
    b_start();
    b_send(mem_addr(1'b1), ack);
    check_eq("R10", "read address ack after repeated start", ack, 1);
    for (int i = 0; i < n; i++) begin
      b_recv(i < n - 1, got);
      check_eq(req, $sformatf("read page %0d word %0h", mpage, mptr), got, model[flat(mpage, mptr)]);
      mptr = (mptr + 1) % 256;
    end
    tick(Q);
    check_eq("R4", "sda released after NACK", sda_oe, 0);
    b_stop();
  endtask

  task automatic tx_cmd(input logic [6:0] a7, input int exp_ack, input string req);
    bit ack;
    b_start();
    b_send({a7, 1'b0}, ack);
    check_eq(req, $sformatf("command %0h ack", a7), ack, exp_ack);
    b_stop();
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 11) & 8'hFF);
  endfunction

  // Scenarios
  task automatic t_reset();
    logic [7:0] d [4];
    check_eq("R1", "sda_oe after reset", sda_oe, 0);
    d = '{8'hA5, 8'h00, 8'h00, 8'h00};
    tx_write(8'h20, d, 1, "R1");
    d = '{8'h5A, 8'h00, 8'h00, 8'h00};
    tx_write(8'hA0, d, 1, "R1");
    tx_cmd(7'h36, 1, "R6");
    mpage = 0;
    tx_read(8'h20, 1, "R1");
    tx_read(8'hA0, 1, "R1");
  endtask

  task automatic t_address();
    bit ack;
    b_start();
    b_send({7'h51, 1'b0}, ack);
    check_eq("R2", "foreign address 0x51 nack", ack, 0);
    b_send(8'h00, ack);
    check_eq("R2", "byte after foreign address nack", ack, 0);
    b_stop();
    sa = 3'd5;
    b_start();
    b_send({7'h50, 1'b0}, ack);
    check_eq("R2", "0x50 nack when slot is 5", ack, 0);
    b_stop();
    b_start();
    b_send({7'h55, 1'b1}, ack);
    check_eq("R2", "0x55 read ack when slot is 5", ack, 1);
    begin
      logic [7:0] got;
      b_recv(1'b0, got);
    end
    b_stop();
    mptr = (mptr + 1) % 256;
    tx_read(8'h20, 1, "R2");
    sa = 3'd0;
  endtask

  task automatic t_burst();
    logic [7:0] d [4];
    for (int i = 0; i < 4; i++) d[i] = pat(i + 3);
    tx_write(8'h10, d, 4, "R3");
    tx_read(8'h10, 4, "R4");
  endtask

  task automatic t_wrap();
    logic [7:0] d [4];
    d = '{8'hE1, 8'hE2, 8'hE3, 8'hE4};
    tx_write(8'hFE, d, 3, "R5");
    tx_read(8'hFE, 3, "R5");
    tx_read(8'h00, 1, "R5");
  endtask

  task automatic t_pointer_keep();
    bit ack;
    logic [7:0] d [4];
    logic [7:0] got;
    d = '{8'h3C, 8'h00, 8'h00, 8'h00};
    tx_write(8'h40, d, 1, "R3");
    b_start();
    b_send(mem_addr(1'b0), ack);
    b_send(8'h40, ack);
    b_stop();
    b_start();
    b_send(mem_addr(1'b1), ack);
    check_eq("R10", "read address ack after stop", ack, 1);
    b_recv(1'b0, got);
    check_eq("R5", "current-address read keeps pointer", got, 8'h3C);
    b_stop();
  endtask

  task automatic t_pages();
    logic [7:0] d [4];
    tx_cmd(7'h37, 1, "R6");
    mpage = 1;
    d = '{8'h77, 8'h00, 8'h00, 8'h00};
    tx_write(8'h10, d, 1, "R6");
    d = '{8'h88, 8'h00, 8'h00, 8'h00};
    tx_write(8'h90, d, 1, "R6");
    tx_read(8'h10, 1, "R6");
    tx_read(8'h90, 1, "R6");
    tx_cmd(7'h36, 1, "R6");
    mpage = 0;
    tx_read(8'h10, 1, "R6");
    tx_cmd(7'h37, 1, "R6");
    mpage = 1;
    tx_read(8'h10, 1, "R6");
    tx_cmd(7'h36, 1, "R6");
    mpage = 0;
  endtask

  task automatic t_protect();
    logic [7:0] d [4];
    hv = 1'b0;
    tx_cmd(7'h31, 0, "R8");
    d = '{8'h11, 8'h00, 8'h00, 8'h00};
    tx_write(8'h80, d, 1, "R8");
    tx_read(8'h80, 1, "R8");
    hv = 1'b1;
    tx_cmd(7'h31, 1, "R8");
    mwp[1] = 1'b1;
    tx_cmd(7'h33, 1, "R8");
    mwp[3] = 1'b1;
    hv = 1'b0;
    d = '{8'h22, 8'h00, 8'h00, 8'h00};
    tx_write(8'h80, d, 1, "R7");
    tx_read(8'h80, 1, "R7");
    d = '{8'h23, 8'h00, 8'h00, 8'h00};
    tx_write(8'h00, d, 1, "R7");
    tx_read(8'h00, 1, "R7");
    tx_cmd(7'h37, 1, "R6");
    mpage = 1;
    d = '{8'h44, 8'h00, 8'h00, 8'h00};
    tx_write(8'h90, d, 1, "R7");
    tx_read(8'h90, 1, "R7");
    d = '{8'h45, 8'h00, 8'h00, 8'h00};
    tx_write(8'h10, d, 1, "R7");
    tx_read(8'h10, 1, "R7");
    tx_cmd(7'h34, 0, "R8");
    tx_write(8'h90, d, 1, "R8");
    tx_read(8'h90, 1, "R8");
    hv = 1'b1;
    tx_cmd(7'h34, 1, "R8");
    mwp = 4'b0000;
    hv = 1'b0;
    d = '{8'h46, 8'h00, 8'h00, 8'h00};
    tx_write(8'h90, d, 1, "R8");
    tx_read(8'h90, 1, "R8");
    tx_cmd(7'h36, 1, "R6");
    mpage = 0;
    tx_write(8'h80, d, 1, "R8");
    tx_read(8'h80, 1, "R8");
  endtask

  task automatic t_cmd_edges();
    bit ack;
    b_start();
    b_send({7'h36, 1'b0}, ack);
    check_eq("R9", "page command ack", ack, 1);
    b_send(8'h5D, ack);
    check_eq("R9", "byte after command nack", ack, 0);
    b_stop();
    b_start();
    b_send({7'h36, 1'b1}, ack);
    check_eq("R9", "read-direction command nack", ack, 0);
    b_stop();
    hv = 1'b1;
    b_start();
    b_send({7'h32, 1'b1}, ack);
    check_eq("R9", "read-direction protect nack", ack, 0);
    b_stop();
    hv = 1'b0;
    tx_read(8'h10, 1, "R9");
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_address();
    t_burst();
    t_wrap();
    t_pointer_keep();
    t_pages();
    t_protect();
    t_cmd_edges();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(190000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule